// File: doc/BRIEF.md
# Ringing-to-Talk Transition Sequencer

This block sits on the controller side of a solid-state line access switch and moves a subscriber line from the ringing state to the talk state. It drives the switch's three mode inputs (ring, test-in, test-out) and the enable of an open-drain pull-down on the switch's force-off pin. That pin is only ever pulled to ground or left floating.

A start pulse begins one transition. The method is chosen with a two-bit select and is sampled with the start pulse. The first method is make-before-break, which goes straight to the talk code. The second is break-before-make through the mode inputs, which holds the all-off code first. The third is break-before-make through the force-off pin: the mode bits are swapped under a forced all-off, and the pin is then released. The hold time is a programmable count of clock cycles and should cover half a ringing period, for example 25 ms at 20 Hz ringing. A one-cycle done flag marks the moment the line is in talk. Ringing cadence and ring-trip detection belong to other blocks.

Top module: `ring_talk_seq`

## Requirements
- R1: During reset and after it, the mode outputs carry the ringing code ring=1, test-in=0, test-out=0. The force-off enable and done are both 0.
- R2: With method 00 (make-before-break), the mode outputs change to the talk code 000 in the cycle after the clock edge that samples start. Done is 1 in that same cycle. The force-off enable stays 0 throughout.
- R3: With method 01 or 11 (break-before-make through the mode inputs), the mode outputs carry the all-off code 111 for exactly N cycles, starting in the cycle after the edge that samples start. After that they carry the talk code 000.
- R4: With method 10 (break-before-make through the force-off pin), the force-off enable rises in the cycle after the edge that samples start, while the ringing code is still in place. The mode bits switch to talk one cycle later. The enable stays high for N cycles in total and falls in the same cycle that done pulses.
- R5: N is the value of the hold-count input at the edge that samples start. Method 01 or 11 treats a value of 0 as 1. Method 10 treats a value below 2 as 2.
- R6: While a sequence is running, the block ignores start pulses and any change to the method select or the hold count.
- R7: Done is high for exactly one cycle per sequence, and only while the talk code is in place and the force-off enable is 0.
- R8: Once talk is reached, the outputs keep the talk code with the force-off enable at 0, and further start pulses have no effect until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a ringing-to-talk transition |
| method | input | 2 | 00 make-before-break, 01/11 break-before-make by mode code, 10 break-before-make by force-off |
| half_period | input | CNT_W | Hold count in clock cycles (half a ringing period) |
| ring_o | output | 1 | Ring mode input of the switch |
| tin_o | output | 1 | Test-in mode input of the switch |
| tout_o | output | 1 | Test-out mode input of the switch |
| force_off_en | output | 1 | 1 turns on the pull-down of the force-off pin; 0 leaves it floating |
| done | output | 1 | One-cycle pulse when talk is established |

## Verification
The transition is run under every method code, including the alias 11. One set of runs uses hold counts that are taken as given. Another uses counts of 0 and 1, which must be raised to the minimum. A run of method 00 tells the direct path apart from the held paths. Long and short counts expose off-by-one errors in the length of the all-off window or of the force-off window. For the force-off method, one run sends extra start pulses and changes the count mid-sequence, to show that the sampled values govern. Start pulses sent after talk confirm that the final state holds.

// File: rtl/ring_talk_seq.sv
module ring_talk_seq #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       method,
  input  logic [CNT_W-1:0] half_period,
  output logic             ring_o,
  output logic             tin_o,
  output logic             tout_o,
  output logic             force_off_en,
  output logic             done
);
  localparam logic [2:0] CODE_RING  = 3'b100;
  localparam logic [2:0] CODE_TALK  = 3'b000;
  localparam logic [2:0] CODE_ALLOFF = 3'b111;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  typedef enum logic [1:0] {S_RING, S_HOLD, S_TALK} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic             alt_q;
  logic [2:0]       mode_q;
  logic             fo_q;
  logic             done_q;

  wire sel_mbb = (method == 2'b00);
  wire sel_alt = (method == 2'b10);

  wire [CNT_W-1:0] load_alt = (half_period < TWO) ? ONE : half_period - ONE;
  wire [CNT_W-1:0] load_bbm = (half_period == '0) ? '0 : half_period - ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_RING;
      cnt    <= '0;
      alt_q  <= 1'b0;
      mode_q <= CODE_RING;
      fo_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_RING: if (start) begin
          if (sel_mbb) begin
            mode_q <= CODE_TALK;
            done_q <= 1'b1;
            st     <= S_TALK;
          end else if (sel_alt) begin
            alt_q <= 1'b1;
            fo_q  <= 1'b1;
            cnt   <= load_alt;
            st    <= S_HOLD;
          end else begin
            alt_q  <= 1'b0;
            mode_q <= CODE_ALLOFF;
            cnt    <= load_bbm;
            st     <= S_HOLD;
          end
        end
        S_HOLD: begin
          if (cnt == '0) begin
            mode_q <= CODE_TALK;
            fo_q   <= 1'b0;
            done_q <= 1'b1;
            st     <= S_TALK;
          end else begin
            cnt <= cnt - ONE;
            if (alt_q) mode_q <= CODE_TALK;
          end
        end
        default: ;
      endcase
    end
  end

  assign {ring_o, tin_o, tout_o} = mode_q;
  assign force_off_en = fo_q;
  assign done = done_q;
endmodule

// File: rtl/ring_talk_seq_chk.sv
module ring_talk_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ring_o,
  input logic tin_o,
  input logic tout_o,
  input logic force_off_en,
  input logic done
);
  wire talk_code = !ring_o && !tin_o && !tout_o;
  wire ring_code = ring_o && !tin_o && !tout_o;

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_in_talk_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> talk_code && !force_off_en);
  p_fo_enter_ring_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(force_off_en) |-> ring_code);
  p_fo_leave_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(force_off_en) |-> talk_code && done);
  p_talk_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (talk_code && !force_off_en) |=> (talk_code && !force_off_en));
  p_test_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tin_o == tout_o);
  p_alloff_from_ring_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tin_o) |-> $past(ring_o) && !$past(force_off_en));
endmodule

bind ring_talk_seq ring_talk_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ring_o(ring_o), .tin_o(tin_o),
  .tout_o(tout_o), .force_off_en(force_off_en), .done(done)
);

// File: tb/tb_ring_talk_seq.sv
`timescale 1ns/1ps
module tb_ring_talk_seq;
  localparam int W = 24;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] method = 2'b00;
  logic [W-1:0] half_period = '0;
  logic ring_o, tin_o, tout_o, force_off_en, done;

  ring_talk_seq #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .method(method),
    .half_period(half_period), .ring_o(ring_o), .tin_o(tin_o),
    .tout_o(tout_o), .force_off_en(force_off_en), .done(done));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  // behavioural reference: phase 0 ringing, 1 holding, 2 talk
  int ph = 0, m = 0, need = 0, el = 0;
  logic [2:0] e_mode = 3'b100;
  logic e_fo = 0, e_done = 0;
  string tag = "R1";

  always @(posedge clk) begin
    e_done = 0;
    if (!rst_n) begin
      ph = 0; e_mode = 3'b100; e_fo = 0; tag = "R1";
    end else if (ph == 0) begin
      if (start) begin
        m = int'(method);
        if (m == 0) begin
          ph = 2; e_mode = 3'b000; e_done = 1; tag = "R2";
        end else if (m == 2) begin
          need = (half_period < 2) ? 2 : int'(half_period);
          tag = (half_period < 2) ? "R5" : "R4";
          el = 1; ph = 1; e_fo = 1;
        end else begin
          need = (half_period == 0) ? 1 : int'(half_period);
          tag = (half_period == 0) ? "R5" : "R3";
          el = 1; ph = 1; e_mode = 3'b111;
        end
      end
    end else if (ph == 1) begin
      if (start) tag = "R6";
      if (el == need) begin
        ph = 2; e_mode = 3'b000; e_fo = 0; e_done = 1;
      end else begin
        el++;
        if (m == 2) e_mode = 3'b000;
      end
    end else begin
      tag = "R8";
    end
  end

  always @(negedge clk) if (!finished) begin
    checks++;
    if ({ring_o, tin_o, tout_o} !== e_mode || force_off_en !== e_fo) begin
      fails++;
      $display("FAIL %s: mode/fo = %b/%b expected %b/%b at %0t", tag,
               {ring_o, tin_o, tout_o}, force_off_en, e_mode, e_fo, $time);
    end
    checks++;
    if (done !== e_done) begin
      fails++;
      $display("FAIL R7 (%s): done = %b expected %b at %0t", tag, done, e_done, $time);
    end
  end

  task automatic go(input logic [1:0] meth, input int n);
    @(negedge clk);
    method = meth; half_period = W'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic restart();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R2 make-before-break, then R8 starts ignored in talk
    go(2'b00, 9);
    repeat (3) @(negedge clk);
    go(2'b01, 4);
    repeat (6) @(negedge clk);
    // R3 break-before-make by code, N=5
    restart();
    go(2'b01, 5);
    repeat (8) @(negedge clk);
    // R5 count 0 treated as 1, alias method 11
    restart();
    go(2'b11, 0);
    repeat (4) @(negedge clk);
    restart();
    go(2'b11, 3);
    repeat (6) @(negedge clk);
    // R4 force-off method, R6 extra starts and count change mid-run
    restart();
    go(2'b10, 6);
    @(negedge clk);
    method = 2'b00; half_period = W'(1); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (8) @(negedge clk);
    // R5 force-off method with count 1 raised to 2
    restart();
    go(2'b10, 1);
    repeat (5) @(negedge clk);
    // long hold
    restart();
    go(2'b10, 40);
    repeat (45) @(negedge clk);
    finish_run();
  end
endmodule